// File: doc/BRIEF.md
# Three-Wire Incremental Wiper Controller

This block holds the tap position of a 100-step digital potentiometer. Three control lines set that position: an active-low select, a direction level and an increment strobe. While the block is selected, each falling edge of the strobe moves the wiper one step up or down. The position saturates at 0 and at 99, and it is driven out as a 7-bit binary code.

The block can also commit the live position to a storage register that models a non-volatile cell. The strobe level at the moment the select line is released decides what happens. If the strobe is high, the position is committed and a busy window starts. If the strobe is low, the select is dropped and nothing is stored. After every reset the live position is reloaded from the committed value. A separate power-on clear sets the committed value to a mid-scale default.

All three control lines are asynchronous to the system clock. Each passes through a two-flop synchronizer before its edges are detected.

Top module: `wiper_ctrl`

## Requirements
- R1: After `por_n` and `rst_n` are released together, the position reads DEFAULT_POS (50) and `store_busy` is 0.
- R2: While `sel_n` is high, strobe and direction activity leave the position unchanged.
- R3: With `sel_n` low, a falling strobe edge changes the position by +1 if `dir_up` is 1, or by -1 if `dir_up` is 0. The direction is taken at the falling edge, so a change of `dir_up` while the strobe is low has no effect on that step.
- R4: The position stays within 0..99. A step up at 99 or a step down at 0 leaves it unchanged.
- R5: A rising edge of `sel_n` while the strobe is high commits the position. `store_busy` then stays high for exactly STORE_CYCLES clocks, and a later reset recalls the committed value.
- R6: A rising edge of `sel_n` while the strobe is low commits nothing. A later reset recalls the value committed earlier.
- R7: Stepping never alters the committed value. Only a commit does.
- R8: While `store_busy` is high, falling strobe edges and new commit requests are ignored.
- R9: A strobe edge or a select edge takes effect at the third rising clock edge after the input changes, provided the input settled before the first of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; causes a recall |
| por_n | input | 1 | Active-low power-on clear of the committed value to DEFAULT_POS |
| sel_n | input | 1 | Active-low select; its rising edge takes the store-or-discard decision |
| dir_up | input | 1 | Step direction: 1 steps toward 99, 0 steps toward 0 |
| strobe | input | 1 | Increment strobe; acts on falling edges |
| wiper_pos | output | POS_W | Binary tap position, 0..NUM_POS-1 |
| store_busy | output | 1 | High during the commit busy window |

## Verification
The assertions check, on every cycle:
- the position stays in range;
- each move is at most one step;
- the position is frozen while the block is deselected and while it is busy;
- the committed value equals the live position when a busy window opens;
- the committed value changes only when a busy window opens.

Some behaviour shows only through the bench scenarios, which recall the committed value through a reset at the ports:
- the strobe-level store-or-discard decision;
- the direction being taken at the falling edge;
- the three-edge latency;
- saturation after long step runs.

A cycle-accurate behavioural model runs alongside the design and backs all of these checks.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Synchronized view of the three control lines
  typedef struct packed {
    logic sel_n;
    logic dir_up;
    logic strobe;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, dir_up: 1'b0, strobe: 1'b0};
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int NUM_POS = 100,
  parameter int POS_W   = $clog2(NUM_POS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  input  logic             step_en,
  input  logic             up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP = POS_W'(NUM_POS - 1);

  logic [POS_W-1:0] pos_d;
  logic             pos_en;

  always_comb begin
    pos_d  = pos;
    pos_en = 1'b0;
    if (load_en) begin
      pos_d  = load_val;
      pos_en = 1'b1;
    end else if (step_en) begin
      if (up && pos != TOP) begin
        pos_d  = pos + POS_W'(1);
        pos_en = 1'b1;
      end else if (!up && pos != '0) begin
        pos_d  = pos - POS_W'(1);
        pos_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (pos_en) pos <= pos_d;
  end
endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int POS_W        = 7,
  parameter int DEFAULT_POS  = 50,
  parameter int STORE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             commit,
  input  logic [POS_W-1:0] data,
  output logic [POS_W-1:0] stored,
  output logic             busy
);
  localparam int CNT_W = $clog2(STORE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (busy)        cnt_d = cnt_q - CNT_W'(1);
    else if (commit) cnt_d = CNT_W'(STORE_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Storage cell: survives rst_n, cleared only by power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                stored <= POS_W'(DEFAULT_POS);
    else if (commit && !busy)  stored <= data;
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int NUM_POS      = 100,
  parameter int DEFAULT_POS  = 50,
  parameter int STORE_CYCLES = 16,
  parameter int POS_W        = $clog2(NUM_POS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             sel_n,
  input  logic             dir_up,
  input  logic             strobe,
  output logic [POS_W-1:0] wiper_pos,
  output logic             store_busy
);
  logic [1:0]       rst_sync_q;
  logic             irst_n;
  ctl_t             ctl_raw, ctl_s;
  logic             sel_prev_q, strobe_prev_q, recall_q;
  logic             sel_s;
  logic             strobe_fall, sel_rise, step_en, commit;
  logic [POS_W-1:0] stored_pos;

  // Reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign irst_n = rst_sync_q[1];

  assign ctl_raw = '{sel_n: sel_n, dir_up: dir_up, strobe: strobe};

  wiper_sync #(.W($bits(ctl_t)), .RST_VAL(CTL_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (irst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  assign sel_s = ctl_s.sel_n;

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      sel_prev_q    <= 1'b1;
      strobe_prev_q <= 1'b0;
      recall_q      <= 1'b1;
    end else begin
      sel_prev_q    <= ctl_s.sel_n;
      strobe_prev_q <= ctl_s.strobe;
      recall_q      <= 1'b0;
    end
  end

  assign strobe_fall = strobe_prev_q & ~ctl_s.strobe;
  assign sel_rise    = ~sel_prev_q & ctl_s.sel_n;
  assign step_en     = strobe_fall & ~ctl_s.sel_n & ~store_busy & ~recall_q;
  assign commit      = sel_rise & ctl_s.strobe & ~store_busy & ~recall_q;

  wiper_counter #(.NUM_POS(NUM_POS), .POS_W(POS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (irst_n),
    .load_en  (recall_q),
    .load_val (stored_pos),
    .step_en  (step_en),
    .up       (ctl_s.dir_up),
    .pos      (wiper_pos)
  );

  wiper_store #(.POS_W(POS_W), .DEFAULT_POS(DEFAULT_POS),
                .STORE_CYCLES(STORE_CYCLES)) u_store (
    .clk    (clk),
    .rst_n  (irst_n),
    .por_n  (por_n),
    .commit (commit),
    .data   (wiper_pos),
    .stored (stored_pos),
    .busy   (store_busy)
  );
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int NUM_POS = 100,
  parameter int POS_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic [POS_W-1:0] wiper_pos,
  input logic             store_busy,
  input logic             recall_q,
  input logic             sel_s,
  input logic [POS_W-1:0] stored_pos
);
  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_pos <= POS_W'(NUM_POS - 1));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_busy |=> $stable(wiper_pos));

  // R2
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && !recall_q) |=> $stable(wiper_pos));

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_q |=> (wiper_pos == $past(wiper_pos) ||
                   wiper_pos == $past(wiper_pos) + POS_W'(1) ||
                   wiper_pos == $past(wiper_pos) - POS_W'(1)));

  // R5
  commit_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_busy) |-> stored_pos == wiper_pos);

  // R7
  nv_change_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !$stable(stored_pos) |-> $rose(store_busy));
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.NUM_POS(NUM_POS), .POS_W(POS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_n      (por_n),
  .wiper_pos  (wiper_pos),
  .store_busy (store_busy),
  .recall_q   (recall_q),
  .sel_s      (sel_s),
  .stored_pos (stored_pos)
);

// File: tb/wiper_ctrl_test.sv
module wiper_ctrl_test;
  localparam int NUM_POS = 100;
  localparam int DEFPOS  = 50;
  localparam int STORE   = 16;
  localparam int POS_W   = 7;

  logic clk = 1'b0;
  logic rst_n, por_n, sel_n, dir_up, strobe;
  logic [POS_W-1:0] wiper_pos;
  logic store_busy;

  int errors = 0, checks = 0;
  bit cmp_on = 0;
  int m_pos, m_nv, m_busy;
  bit h_sel[$], h_dir[$], h_stb[$];

  always #10 clk = ~clk;

  wiper_ctrl #(.NUM_POS(NUM_POS), .DEFAULT_POS(DEFPOS), .STORE_CYCLES(STORE)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sel_n(sel_n),
    .dir_up(dir_up), .strobe(strobe), .wiper_pos(wiper_pos), .store_busy(store_busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural cycle model (R9 latency: input history of three samples)
  always @(posedge clk) begin
    if (cmp_on) begin
      bit fall, rise;
      fall = h_stb[2] && !h_stb[1];
      rise = !h_sel[2] && h_sel[1];
      if (m_busy > 0) m_busy--;
      else begin
        if (fall && !h_sel[1]) begin
          if (h_dir[1]) begin if (m_pos < NUM_POS - 1) m_pos++; end
          else          begin if (m_pos > 0) m_pos--; end
        end
        if (rise && h_stb[1]) begin m_nv = m_pos; m_busy = STORE; end
      end
      h_sel.push_front(sel_n);   void'(h_sel.pop_back());
      h_dir.push_front(dir_up);  void'(h_dir.pop_back());
      h_stb.push_front(strobe);  void'(h_stb.pop_back());
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(wiper_pos == POS_W'(m_pos), "R9 position vs model", int'(wiper_pos), m_pos);
      check(store_busy == (m_busy > 0), "R5 R8 busy vs model", int'(store_busy), int'(m_busy > 0));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit clear_nv, input string req);
    cmp_on = 0;
    rst_n = 1'b0;
    if (clear_nv) begin por_n = 1'b0; m_nv = DEFPOS; end
    cyc(3);
    rst_n = 1'b1; por_n = 1'b1;
    cyc(6);
    check(wiper_pos == POS_W'(m_nv), req, int'(wiper_pos), m_nv);
    check(store_busy == 1'b0, "R1 busy idle after reset", int'(store_busy), 0);
    m_pos = m_nv; m_busy = 0;
    h_sel = {sel_n, sel_n, sel_n};
    h_dir = {dir_up, dir_up, dir_up};
    h_stb = {strobe, strobe, strobe};
    cmp_on = 1;
  endtask

  task automatic pulse(input bit up);
    dir_up = up; cyc(2);
    strobe = 1'b0; cyc(4);
    strobe = 1'b1; cyc(4);
  endtask

  task automatic select();
    strobe = 1'b1; sel_n = 1'b0; cyc(3);
  endtask

  task automatic release_store();
    strobe = 1'b1; cyc(1);
    sel_n = 1'b1; cyc(4);
  endtask

  task automatic release_discard(input bit up);
    dir_up = up; cyc(2);
    strobe = 1'b0; cyc(4);
    sel_n = 1'b1; cyc(4);
    strobe = 1'b1; cyc(4);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0; sel_n = 1'b1; dir_up = 1'b0; strobe = 1'b1;
    m_nv = DEFPOS;
    do_reset(1, "R1 power-on default");

    // R3 up and down
    select();
    for (int i = 0; i < 3; i++) pulse(1);
    check(wiper_pos == 7'd53, "R3 three steps up", int'(wiper_pos), 53);
    pulse(0);
    check(wiper_pos == 7'd52, "R3 one step down", int'(wiper_pos), 52);

    // R3 direction flipped while strobe low: step follows the level at the fall
    dir_up = 1'b1; cyc(2);
    strobe = 1'b0; cyc(1);
    dir_up = 1'b0; cyc(3);
    strobe = 1'b1; cyc(4);
    check(wiper_pos == 7'd53, "R3 direction sampled at fall", int'(wiper_pos), 53);

    // R6 discard release (its falling strobe is itself a step up)
    release_discard(1);
    check(wiper_pos == 7'd54, "R6 discard keeps live position", int'(wiper_pos), 54);
    check(store_busy == 1'b0, "R6 no busy on discard", int'(store_busy), 0);

    // R2 activity while deselected
    for (int i = 0; i < 4; i++) pulse(i % 2 == 0);
    pulse(0);
    check(wiper_pos == 7'd54, "R2 deselected strobes ignored", int'(wiper_pos), 54);

    // R6 R7: no commit yet, recall returns default
    do_reset(0, "R6 R7 recall after discard");

    // R5 commit with strobe high
    select();
    for (int i = 0; i < 4; i++) pulse(1);
    release_store();
    check(store_busy == 1'b1, "R5 busy after commit", int'(store_busy), 1);

    // R8 steps during busy ignored
    sel_n = 1'b0; cyc(1);
    strobe = 1'b0; cyc(3);
    strobe = 1'b1; cyc(3);
    check(wiper_pos == 7'd54, "R8 step ignored while busy", int'(wiper_pos), 54);
    sel_n = 1'b1; cyc(25);
    check(store_busy == 1'b0, "R5 busy window ends", int'(store_busy), 0);
    do_reset(0, "R5 recall of committed value");

    // R4 saturation at top and bottom
    select();
    for (int i = 0; i < 50; i++) pulse(1);
    check(wiper_pos == 7'd99, "R4 saturate at 99", int'(wiper_pos), 99);
    pulse(1);
    check(wiper_pos == 7'd99, "R4 step up at 99 held", int'(wiper_pos), 99);
    for (int i = 0; i < 101; i++) pulse(0);
    check(wiper_pos == 7'd0, "R4 saturate at 0", int'(wiper_pos), 0);

    // R6 R7: discard after long stepping keeps the committed 54
    release_discard(0);
    check(wiper_pos == 7'd0, "R4 step down at 0 held", int'(wiper_pos), 0);
    do_reset(0, "R6 R7 committed value survives stepping");

    // R1 power-on clear
    do_reset(1, "R1 power-on clear to default");

    cmp_on = 0;
    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule